// File: doc/BRIEF.md
# Video Timing Mode Checker

This block decides whether an incoming digitised video stream runs at the one resolution it is configured for. It watches only the horizontal and vertical sync pulses. Both are brought into a free-running reference clock domain that has no fixed ratio to the pixel clock. The block times each line and each frame there, as a count of reference cycles, and compares the counts against a window around a nominal value. The window absorbs the fractional clock ratio and the jitter that resynchronisation adds.

After enough consecutive clean frames, the block raises a video-ready level for a downstream control state machine. One bad frame, or a sync signal that goes silent, drops that level again. Each detected rising edge of vertical sync also produces a one-cycle start-of-frame strobe. A packetizer can use the strobe to follow the source refresh rate, whether the mode has locked or not. The most recent line and frame counts are also available as outputs.

Top module: `vtm_mode_checker`

## Requirements
- R1: While reset is applied and directly after it, `video_ready_o` and `sof_o` are 0, and both period outputs read 0.
- R2: Each rising edge of `vsync_i` produces exactly one `sof_o` pulse, one reference cycle wide. The pulse is high in the cycle that follows the second rising edge of `clk_ref` at which `vsync_i` is sampled high.
- R3: `line_period_o` holds the number of reference cycles between the two most recent detected rising edges of `hsync_i`. It changes only after such an edge.
- R4: `frame_period_o` holds the number of reference cycles between the two most recent detected rising edges of `vsync_i`. It changes only after such an edge.
- R5: The first vsync edge after reset only starts timing. `video_ready_o` rises at the vsync edge that closes the LOCK_FRAMES-th consecutive good frame (2 by default), and not earlier.
- R6: A frame is good only if every line measured inside it lies within LINE_NOM ± LINE_TOL, both bounds included.
- R7: A frame is good only if its own period lies within FRAME_NOM ± FRAME_TOL, both bounds included.
- R8: A frame that is not good clears `video_ready_o` at the vsync edge that closes it, and restarts the lock count.
- R9: If the count since the last vsync edge reaches 2 × FRAME_NOM, `video_ready_o` clears and the lock count restarts.
- R10: If the count since the last hsync edge reaches 2 × LINE_NOM, `video_ready_o` clears and the lock count restarts.
- R11: The period counters stop at their all-ones value instead of wrapping, so a long gap cannot alias onto an in-range period.
- R12: `sof_o` pulses on every detected vsync edge, whether or not the mode has locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk_ref |
| hsync_i | input | 1 | Horizontal sync from the pixel domain, active on its rising edge |
| vsync_i | input | 1 | Vertical sync from the pixel domain, active on its rising edge |
| video_ready_o | output | 1 | High while the measured timing matches the configured mode |
| sof_o | output | 1 | One-cycle start-of-frame strobe |
| line_period_o | output | LINE_W | Last measured line period in reference cycles |
| frame_period_o | output | FRAME_W | Last measured frame period in reference cycles |

## Verification
A sync rise that the bench drives at a falling clock edge yields `sof_o` in the cycle after the second rising edge. The period outputs take their new value one edge later. `video_ready_o` changes on the third rising edge after the vsync rise that closes a frame, and a timeout shows up three cycles after the threshold count is reached. The bench drives every stimulus on falling edges and reads results on falling edges. Its checks fall either at the exact cycle of the strobe or at the end of a frame or idle stretch, which is many cycles after the latest change can land. Because it generates the sync pulses in reference cycles, every expected period is an exact integer. Tolerance bounds and timeout thresholds are therefore probed on both sides.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

  // True when a measured count lies inside nominal +/- tolerance (inclusive).
  function automatic logic in_window(input int unsigned meas,
                                     input int unsigned nom,
                                     input int unsigned tol);
    return ((meas + tol) >= nom) && (meas <= (nom + tol));
  endfunction

endpackage

// File: rtl/vtm_edge_sync.sv
module vtm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  // stages [STAGES-1:0] synchronise, stage [STAGES] remembers the previous value
  logic [STAGES:0] shift_q;
  logic [STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/vtm_period_meter.sv
module vtm_period_meter #(
  parameter int unsigned NOM = 1098,
  parameter int          W   = $clog2(2 * NOM + 2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] count_o,
  output logic         primed_o,
  output logic         timeout_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] TO_LIM  = W'(2 * NOM);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic         primed_q, primed_d;
  logic         per_en;

  assign per_en = edge_i;

  always_comb begin
    cnt_d    = cnt_q;
    per_d    = per_q;
    primed_d = primed_q;
    if (edge_i) begin
      cnt_d    = W'(1);
      primed_d = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + W'(1);
    end
    if (per_en) per_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      if (per_en) per_q <= per_d;
    end
  end

  assign period_o  = per_q;
  assign count_o   = cnt_q;
  assign primed_o  = primed_q;
  assign timeout_o = (cnt_q >= TO_LIM);

endmodule

// File: rtl/vtm_lock_ctrl.sv
module vtm_lock_ctrl #(
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_vld,
  input  logic line_ok,
  input  logic frame_edge,
  input  logic frame_vld,
  input  logic frame_ok,
  input  logic stall,
  output logic ready_o
);

  localparam int             GW       = $clog2(LOCK_FRAMES + 1);
  localparam logic [GW-1:0]  GOOD_MAX = GW'(LOCK_FRAMES);

  logic          line_bad_q, line_bad_d;
  logic          line_seen_q, line_seen_d;
  logic [GW-1:0] good_q, good_d;
  logic          ready_q, ready_d;
  logic          bad_eff, seen_eff, frame_good;

  always_comb begin
    // a line edge coinciding with the vsync edge still belongs to the closing frame
    bad_eff    = line_bad_q | (line_vld & ~line_ok);
    seen_eff   = line_seen_q | line_vld;
    frame_good = frame_ok & ~bad_eff & seen_eff;

    line_bad_d  = bad_eff;
    line_seen_d = seen_eff;
    good_d      = good_q;
    ready_d     = ready_q;

    if (frame_edge) begin
      line_bad_d  = 1'b0;
      line_seen_d = 1'b0;
    end

    if (stall) begin
      good_d  = '0;
      ready_d = 1'b0;
    end else if (frame_vld) begin
      if (frame_good) begin
        good_d  = (good_q == GOOD_MAX) ? GOOD_MAX : good_q + GW'(1);
        ready_d = (good_d == GOOD_MAX);
      end else begin
        good_d  = '0;
        ready_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_bad_q  <= 1'b0;
      line_seen_q <= 1'b0;
      good_q      <= '0;
      ready_q     <= 1'b0;
    end else begin
      line_bad_q  <= line_bad_d;
      line_seen_q <= line_seen_d;
      good_q      <= good_d;
      ready_q     <= ready_d;
    end
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/vtm_mode_checker.sv
module vtm_mode_checker #(
  parameter int unsigned LINE_NOM    = 1098,
  parameter int unsigned LINE_TOL    = 2,
  parameter int unsigned FRAME_NOM   = 885360,
  parameter int unsigned FRAME_TOL   = 64,
  parameter int          LOCK_FRAMES = 2,
  parameter int          SYNC_STAGES = 2,
  parameter int          LINE_W      = $clog2(2 * LINE_NOM + 2),
  parameter int          FRAME_W     = $clog2(2 * FRAME_NOM + 2)
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic               video_ready_o,
  output logic               sof_o,
  output logic [LINE_W-1:0]  line_period_o,
  output logic [FRAME_W-1:0] frame_period_o
);

  logic               hs_edge, vs_edge;
  logic [LINE_W-1:0]  line_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic               line_primed, frame_primed;
  logic               line_to, frame_to, any_timeout;
  logic               line_ok, frame_ok;

  vtm_edge_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_i(hsync_i), .rise_o(hs_edge)
  );

  vtm_edge_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_i(vsync_i), .rise_o(vs_edge)
  );

  vtm_period_meter #(.NOM(LINE_NOM), .W(LINE_W)) u_line_meter (
    .clk(clk_ref), .rst_n(rst_n), .edge_i(hs_edge),
    .period_o(line_period_o), .count_o(line_cnt),
    .primed_o(line_primed), .timeout_o(line_to)
  );

  vtm_period_meter #(.NOM(FRAME_NOM), .W(FRAME_W)) u_frame_meter (
    .clk(clk_ref), .rst_n(rst_n), .edge_i(vs_edge),
    .period_o(frame_period_o), .count_o(frame_cnt),
    .primed_o(frame_primed), .timeout_o(frame_to)
  );

  // the running count at an edge is the period being closed
  assign line_ok     = vtm_pkg::in_window(32'(line_cnt), LINE_NOM, LINE_TOL);
  assign frame_ok    = vtm_pkg::in_window(32'(frame_cnt), FRAME_NOM, FRAME_TOL);
  assign any_timeout = line_to | frame_to;

  vtm_lock_ctrl #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk_ref), .rst_n(rst_n),
    .line_vld(hs_edge & line_primed), .line_ok(line_ok),
    .frame_edge(vs_edge), .frame_vld(vs_edge & frame_primed), .frame_ok(frame_ok),
    .stall(any_timeout), .ready_o(video_ready_o)
  );

  assign sof_o = vs_edge;

endmodule

// File: rtl/vtm_mode_checker_sva.sv
module vtm_mode_checker_sva #(
  parameter int LINE_W  = 11,
  parameter int FRAME_W = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hs_edge,
  input logic               vs_edge,
  input logic               stall,
  input logic [LINE_W-1:0]  line_cnt,
  input logic [FRAME_W-1:0] frame_cnt,
  input logic               sof,
  input logic               ready,
  input logic [LINE_W-1:0]  line_period,
  input logic [FRAME_W-1:0] frame_period
);

  // R2
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n) sof |=> !sof);

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(vs_edge));

  // R8 (drops also allowed by R9, R10)
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(vs_edge) || $past(stall)));

  // R9
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ready);

  // R11
  line_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_edge && (line_cnt == '1)) |=> (line_cnt == '1));

  // R11
  frame_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_edge && (frame_cnt == '1)) |=> (frame_cnt == '1));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_period) |-> $past(hs_edge));

  // R4
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_period) |-> $past(vs_edge));

endmodule

bind vtm_mode_checker vtm_mode_checker_sva #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_sva (
  .clk(clk_ref), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
  .stall(any_timeout), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
  .sof(sof_o), .ready(video_ready_o),
  .line_period(line_period_o), .frame_period(frame_period_o)
);

// File: tb/tb_vtm_mode_checker.sv
module tb_vtm_mode_checker;

  localparam int LN = 20;
  localparam int LT = 2;
  localparam int FN = 200;
  localparam int FT = 8;
  localparam int LW = $clog2(2 * LN + 2);
  localparam int FW = $clog2(2 * FN + 2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hs, vs;
  logic          ready, sof;
  logic [LW-1:0] lper;
  logic [FW-1:0] fper;

  int n_run  = 0;
  int n_fail = 0;
  int sof_cnt = 0;
  int sof_dbl = 0;
  bit sof_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vtm_mode_checker #(
    .LINE_NOM(LN), .LINE_TOL(LT), .FRAME_NOM(FN), .FRAME_TOL(FT), .LOCK_FRAMES(2)
  ) dut (
    .clk_ref(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs),
    .video_ready_o(ready), .sof_o(sof), .line_period_o(lper), .frame_period_o(fper)
  );

  always @(posedge clk) begin
    if (sof) sof_cnt <= sof_cnt + 1;
    if (sof && sof_prev) sof_dbl <= sof_dbl + 1;
    sof_prev <= sof;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sof_cnt = 0; sof_dbl = 0;
  endtask

  task automatic line(input int period, input bit with_vs);
    hs = 1'b1; vs = with_vs;
    repeat (2) @(negedge clk);
    hs = 1'b0; vs = 1'b0;
    repeat (period - 2) @(negedge clk);
  endtask

  // first na lines use period pa, the rest use pb; vsync rides on line 0
  task automatic frame(input int pa, input int na, input int pb, input int lines);
    for (int i = 0; i < lines; i++) line((i < na) ? pa : pb, i == 0);
  endtask

  task automatic lock_up();
    repeat (3) frame(LN, 10, LN, 10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    repeat (2) @(negedge clk);
    check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    do_reset();
    check(ready == 1'b0, "R1", "ready after reset", int'(ready), 0);
    check(sof == 1'b0, "R1", "sof after reset", int'(sof), 0);
    check(lper == '0, "R1", "line period", int'(lper), 0);
    check(fper == '0, "R1", "frame period", int'(fper), 0);
  endtask

  task automatic t_sof_latency();
    do_reset();
    vs = 1'b1;
    @(negedge clk);
    check(sof == 1'b0, "R2", "sof after one edge", int'(sof), 0);
    @(negedge clk);
    check(sof == 1'b1, "R2", "sof after two edges", int'(sof), 1);
    @(negedge clk);
    check(sof == 1'b0, "R2", "sof width", int'(sof), 0);
    check(ready == 1'b0, "R12", "ready while sof without lock", int'(ready), 0);
    vs = 1'b0;
    repeat (4) @(negedge clk);
    check(sof_cnt == 1, "R12", "sof count unlocked", sof_cnt, 1);
  endtask

  task automatic t_lock();
    do_reset();
    repeat (2) frame(LN, 10, LN, 10);
    check(ready == 1'b0, "R5", "ready after two vsync edges", int'(ready), 0);
    check(sof_cnt == 2, "R12", "sof pulses before lock", sof_cnt, 2);
    frame(LN, 10, LN, 10);
    check(ready == 1'b1, "R5", "ready after two good frames", int'(ready), 1);
    check(int'(lper) == LN, "R3", "line period", int'(lper), LN);
    check(int'(fper) == FN, "R4", "frame period", int'(fper), FN);
    check(sof_dbl == 0, "R2", "back-to-back sof", sof_dbl, 0);
  endtask

  task automatic t_line_window();
    do_reset();
    repeat (3) frame(LN + LT, 5, LN - LT, 10);
    check(ready == 1'b1, "R6", "lines at +/-tol bounds", int'(ready), 1);
    frame(LN + LT + 1, 5, LN - LT - 1, 10);
    frame(LN, 10, LN, 10);
    check(ready == 1'b0, "R6", "lines one past tol", int'(ready), 0);
    check(int'(fper) == FN, "R8", "bad-line frame period", int'(fper), FN);
  endtask

  task automatic t_frame_window();
    do_reset();
    repeat (3) frame(LN + 1, 8, LN, 10);
    check(ready == 1'b1, "R7", "frame at +tol bound", int'(ready), 1);
    frame(LN + 1, 9, LN, 10);
    frame(LN, 10, LN, 10);
    check(ready == 1'b0, "R8", "frame one past tol drops ready", int'(ready), 0);
    check(int'(fper) == FN + FT + 1, "R7", "frame period of bad frame", int'(fper), FN + FT + 1);
  endtask

  task automatic t_frame_timeout();
    do_reset();
    lock_up();
    repeat (5) line(LN, 1'b0);
    check(ready == 1'b1, "R9", "ready before frame timeout", int'(ready), 1);
    repeat (10) line(LN, 1'b0);
    check(ready == 1'b0, "R9", "ready after frame timeout", int'(ready), 0);
  endtask

  task automatic t_line_timeout();
    do_reset();
    lock_up();
    repeat (10) @(negedge clk);
    check(ready == 1'b1, "R10", "ready before line timeout", int'(ready), 1);
    repeat (20) @(negedge clk);
    check(ready == 1'b0, "R10", "ready after line timeout", int'(ready), 0);
  endtask

  task automatic t_saturate();
    do_reset();
    lock_up();
    // a wrapping counter would read exactly nominal after this gap
    repeat (512) @(negedge clk);
    frame(LN, 10, LN, 10);
    check(int'(lper) == LN, "R3", "line period after gap", int'(lper), LN);
    frame(LN, 10, LN, 10);
    check(ready == 1'b0, "R11", "gap frame not accepted", int'(ready), 0);
    frame(LN, 10, LN, 10);
    check(ready == 1'b1, "R11", "relock after gap", int'(ready), 1);
  endtask

  initial begin
    t_reset();
    t_sof_latency();
    t_lock();
    t_line_window();
    t_frame_window();
    t_frame_timeout();
    t_line_timeout();
    t_saturate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule